// File: doc/BRIEF.md
# Radix-2 SRT Fractional Divider

This block divides one unsigned 8-bit binary fraction by another, one quotient digit per clock cycle, using the radix-2 SRT recurrence. Each step doubles a 9-bit two's-complement partial remainder. It compares the doubled value against plus and minus one half and picks a redundant digit of +1, 0 or -1. It then subtracts the divisor, adds it, or leaves the doubled value unchanged. The remainder starts out equal to the dividend.

The binary quotient is assembled on the fly, so no conversion pass is needed at the end. A pair of registers holds the quotient so far and the quotient minus one unit in the last place. These registers update on the falling clock edge. The remainder logic updates on the rising edge. The digit chosen at a rising edge is therefore folded into the quotient half a cycle later.

The caller pulses `start` for one rising edge to capture the operands. It then holds `load` high until the quotient has settled, which is 8 steps later. The dividend must be smaller than the divisor. The divisor must be normalised, with its top bit set. Widths are parameterised, with a default of 8 fraction bits.

Top module: `srt_frac_div`

## Requirements
- R1: Driving `rst_n` low clears `quotient` to 0 at once, without waiting for a clock edge, and the quotient stays 0 until a new division is run.
- R2: A rising edge with `start` high captures `dividend` (remainder = 0.dividend) and `divisor`, and restarts the step count. At the falling edge that follows, `quotient` becomes 0, even if it held an earlier result.
- R3: When twice the remainder is at least 1/2 (128 in units of 2^-8), the digit is +1 and the next remainder is 2r - D.
- R4: When twice the remainder is below -1/2 (-128 in units of 2^-8), the digit is -1 and the next remainder is 2r + D.
- R5: When twice the remainder lies in [-1/2, 1/2), the digit is 0 and the next remainder is 2r.
- R6: Exactly 8 steps are taken after `start`. Once the 8th digit has been applied, `quotient` and the remainder hold, even while `load` stays high.
- R7: While `load` is low and `start` is low, no step is taken: `quotient`, the remainder and the step count hold. When `load` returns, the division resumes and gives the same result.
- R8: `quotient` equals the sum over i = 1..8 of digit_i * 2^(8-i), taken modulo 256. For example, 0x55 / 0xFF gives the digits +1,-1,+1,... and the quotient 0x55.
- R9: With a normalised divisor (bit 7 set), the remainder always stays within [-D, +D].
- R10: `quotient` changes only on falling clock edges. A digit picked at a rising edge shows up on `quotient` after the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The remainder updates on the rising edge, the quotient on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Captures the operands at a rising edge and begins a new division |
| load | input | 1 | Step enable. Hold high for the whole division |
| dividend | input | 8 | Dividend fraction 0.xxxxxxxx, smaller than the divisor |
| divisor | input | 8 | Divisor fraction 0.1xxxxxxx |
| quotient | output | 8 | Quotient fraction, built on the fly |

## Verification
The assertions check four things on every cycle. The remainder stays within plus or minus the divisor. The step count never passes 8. A start loads the dividend and clears the count. The remainder holds while paused or finished. At every falling edge they also check that the two on-the-fly registers differ by exactly one unit in the last place. Only the bench scenarios can show that the digits combine into the right quotient for each selection region. The same holds for the half-cycle offset between digit choice and quotient update, and for the result being unchanged by a pause or by extra edges with `load` held high. The asynchronous clearing by reset is likewise shown only by the bench.

// File: rtl/srt_pkg.sv
package srt_pkg;
  // Action the falling-edge quotient registers take on their next update.
  typedef enum logic [2:0] {
    OTF_IDLE  = 3'd0,
    OTF_CLEAR = 3'd1,
    OTF_PLUS  = 3'd2,
    OTF_ZERO  = 3'd3,
    OTF_MINUS = 3'd4
  } otf_cmd_e;
endpackage

// File: rtl/srt_rst_sync.sv
module srt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_n;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/srt_digit_sel.sv
module srt_digit_sel
  import srt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W:0]   rem,
  input  logic [W-1:0] divisor,
  output otf_cmd_e     digit_cmd,
  output logic [W:0]   rem_next
);
  localparam int RW     = W + 2;
  localparam int HALF_I = 1 << (W - 1);
  localparam logic signed [RW-1:0] HALF = RW'(HALF_I);

  logic signed [RW-1:0] twice;
  logic signed [RW-1:0] dext;
  logic signed [RW-1:0] sum;

  always_comb begin
    twice = {rem, 1'b0};
    dext  = $signed({2'b00, divisor});
    if (twice >= HALF) begin
      digit_cmd = OTF_PLUS;
      sum       = twice - dext;
    end else if (twice < -HALF) begin
      digit_cmd = OTF_MINUS;
      sum       = twice + dext;
    end else begin
      digit_cmd = OTF_ZERO;
      sum       = twice;
    end
    rem_next = sum[W:0];
  end
endmodule

// File: rtl/srt_otf.sv
module srt_otf
  import srt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  otf_cmd_e     cmd,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, qm_r;
  logic [W-1:0] q_n, qm_n;

  always_comb begin
    q_n  = q_r;
    qm_n = qm_r;
    case (cmd)
      OTF_CLEAR: begin q_n = '0;                    qm_n = '1;                    end
      OTF_PLUS:  begin q_n = {q_r[W-2:0], 1'b1};    qm_n = {q_r[W-2:0], 1'b0};    end
      OTF_ZERO:  begin q_n = {q_r[W-2:0], 1'b0};    qm_n = {qm_r[W-2:0], 1'b1};   end
      OTF_MINUS: begin q_n = {qm_r[W-2:0], 1'b1};   qm_n = {qm_r[W-2:0], 1'b0};   end
      default:   begin q_n = q_r;                   qm_n = qm_r;                  end
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r  <= '0;
      qm_r <= '0;
    end else begin
      q_r  <= q_n;
      qm_r <= qm_n;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/srt_frac_div.sv
module srt_frac_div
  import srt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic          rst_sync_n;
  logic [W:0]    rem_q, rem_n, rem_step;
  logic [W-1:0]  div_q, div_n;
  logic [CW-1:0] cnt_q, cnt_n;
  otf_cmd_e      cmd_q, cmd_n, digit_cmd;
  logic          step_en;

  srt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  srt_digit_sel #(.W(W)) u_sel (
    .rem       (rem_q),
    .divisor   (div_q),
    .digit_cmd (digit_cmd),
    .rem_next  (rem_step)
  );

  assign step_en = load && !start && (cnt_q < LAST);

  always_comb begin
    rem_n = rem_q;
    div_n = div_q;
    cnt_n = cnt_q;
    cmd_n = OTF_IDLE;
    if (start) begin
      rem_n = {1'b0, dividend};
      div_n = divisor;
      cnt_n = '0;
      cmd_n = OTF_CLEAR;
    end else if (step_en) begin
      rem_n = rem_step;
      cnt_n = cnt_q + CW'(1);
      cmd_n = digit_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rem_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      cmd_q <= OTF_IDLE;
    end else begin
      rem_q <= rem_n;
      div_q <= div_n;
      cnt_q <= cnt_n;
      cmd_q <= cmd_n;
    end
  end

  srt_otf #(.W(W)) u_otf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cmd   (cmd_q),
    .q     (quotient)
  );
endmodule

// File: rtl/srt_frac_div_chk.sv
module srt_frac_div_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         load,
  input logic [W-1:0] dividend,
  input logic [W:0]   rem,
  input logic [W-1:0] dvs,
  input logic [$clog2(W+1)-1:0] cnt
);
  localparam int CW = $clog2(W + 1);
  logic signed [W+1:0] r_ext, d_ext;

  always_comb begin
    r_ext = $signed({rem[W], rem});
    d_ext = $signed({2'b00, dvs});
  end

  assert_rem_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dvs[W-1] |-> (r_ext <= d_ext && r_ext >= -d_ext));

  assert_count_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(W) && !start) |=> $stable(rem));

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !load) |=> ($stable(rem) && $stable(cnt)));

  assert_start_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rem == {1'b0, $past(dividend)} && cnt == '0));
endmodule

module srt_otf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] q,
  input logic [W-1:0] qm
);
  assert_otf_pair_R8: assert property (@(negedge clk) disable iff (!rst_n)
    (q != '0 || qm != '0) |-> (qm == W'(q - 1'b1)));
endmodule

bind srt_frac_div srt_frac_div_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .load     (load),
  .dividend (dividend),
  .rem      (rem_q),
  .dvs      (div_q),
  .cnt      (cnt_q)
);

bind srt_otf srt_otf_chk #(.W(W)) u_otf_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .q     (q_r),
  .qm    (qm_r)
);

// File: tb/srt_frac_div_test.sv
`timescale 1ns/1ps
module srt_frac_div_test;
  logic       clk = 1'b0;
  logic       rst_n, start, load;
  logic [7:0] dividend, divisor;
  logic [7:0] quotient;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  srt_frac_div #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .dividend(dividend), .divisor(divisor), .quotient(quotient)
  );

  typedef struct packed { logic [7:0] x; logic [7:0] d; logic [7:0] q; } vec_t;
  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'h55, 8'hFF, 8'h55},
    '{8'h00, 8'h80, 8'h00},
    '{8'h40, 8'h80, 8'h80},
    '{8'h7F, 8'h80, 8'hFE},
    '{8'h20, 8'hC0, 8'h2B}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: quotient actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] model(input int x, input int d);
    int r = x;
    int q = 0;
    for (int i = 0; i < 8; i++) begin
      int t = 2 * r;
      if (t >= 128)       begin q += 1 << (7 - i); r = t - d; end
      else if (t < -128)  begin q -= 1 << (7 - i); r = t + d; end
      else                r = t;
    end
    return 8'(q);
  endfunction

  task automatic kick(input logic [7:0] x, input logic [7:0] d);
    @(posedge clk); #1;
    start = 1'b1; load = 1'b1; dividend = x; divisor = d;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_div(input logic [7:0] x, input logic [7:0] d);
    kick(x, d);
    repeat (8) @(posedge clk);
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog R6: actual still running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] qa;
    rst_n = 1'b0; start = 1'b0; load = 1'b0; dividend = '0; divisor = '0;
    #10;
    check("R1 reset state", quotient, 8'h00);
    #2.2 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Table of operand/result vectors: R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      run_div(VECS[i].x, VECS[i].d);
      check("R3 R4 R5 R8 table", quotient, VECS[i].q);
    end

    // Model-driven cases over several divisors: R8
    for (int k = 0; k < 4; k++) begin
      logic [7:0] dv;
      dv = (k == 0) ? 8'h80 : (k == 1) ? 8'hA5 : (k == 2) ? 8'hC3 : 8'hFF;
      run_div(8'((int'(dv) * 3) / 4), dv);
      check("R8 model 3/4", quotient, model((int'(dv) * 3) / 4, int'(dv)));
      run_div(dv - 8'd1, dv);
      check("R8 model d-1", quotient, model(int'(dv) - 1, int'(dv)));
    end

    // R2 clear on start, R10 falling-edge update, R6 hold
    run_div(8'h55, 8'hFF);
    kick(8'h40, 8'h80);
    check("R10 unchanged after rising edge", quotient, 8'h55);
    @(negedge clk); #1;
    check("R2 cleared on start", quotient, 8'h00);
    @(posedge clk); #1;
    check("R10 digit not yet applied", quotient, 8'h00);
    @(negedge clk); #1;
    check("R10 digit applied at falling edge", quotient, 8'h01);
    repeat (7) @(posedge clk);
    @(negedge clk); #1;
    check("R6 final result", quotient, 8'h80);
    repeat (6) @(posedge clk);
    #1;
    check("R6 hold after 8 steps", quotient, 8'h80);

    // R7 pause mid-run
    kick(8'h20, 8'hC0);
    repeat (3) @(posedge clk);
    #1 load = 1'b0;
    @(negedge clk); #1;
    qa = quotient;
    check("R7 three digits", qa, 8'h02);
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    check("R7 hold while paused", quotient, qa);
    load = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    check("R7 resumed result", quotient, 8'h2B);

    // R1 asynchronous reset mid-run
    kick(8'h7F, 8'h80);
    repeat (3) @(posedge clk);
    #1.3 rst_n = 1'b0;
    #0.4;
    check("R1 async clear", quotient, 8'h00);
    load = 1'b0;
    #7 rst_n = 1'b1;
    repeat (12) @(posedge clk);
    #1;
    check("R1 stays clear", quotient, 8'h00);
    run_div(8'h55, 8'hFF);
    check("R1 R8 after reset", quotient, 8'h55);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule